// File: doc/BRIEF.md
# Posted-Write Host Bus Bridge

This bridge connects a synchronous host bus to an internal memory array and a small register file. Writes from the host are not made to wait for the internal store. Each write beat goes into a command queue together with its address and a register/memory tag. The host is acknowledged in the cycle after the push. A drain engine then retires one queued command every `DRAIN_CYC` clock cycles, in the order the commands arrived.

Reads are strictly ordered behind posted writes. A read beat is held until the queue is empty, so the data returned always includes every earlier write. If a write burst reaches a full queue, the beat is refused and an active-low stop output ends the burst. The bridge accepts plain bursts, where the address is given with the first beat. It also accepts multiplexed sequential bursts, where an address-latch strobe captures the start address first. In both kinds the address increases by one on every accepted beat.

Top module: `posted_write_bridge`

## Requirements
- R1: While reset is applied and after it is released, `rdy_no` and `stop_no` are high, the queue is empty, and every memory word and register reads as zero.
- R2: A write beat (`wr_i`=1) that finds the queue below `DEPTH` entries is pushed. `rdy_no` is low in the following cycle, whether or not the data has been committed yet.
- R3: The drain engine retires the oldest queued command every `DRAIN_CYC` cycles while the queue is non-empty. The first command is retired `DRAIN_CYC` cycles after the queue becomes non-empty.
- R4: A write beat that finds the queue full is not stored. In the following cycle `stop_no` is low and `rdy_no` is high. `stop_no` stays low until `sel_ni` is sampled high, and it is high in the cycle after that.
- R5: With `DRAIN_CYC`=2 and one beat per cycle, a 32-beat write burst never stops when it starts with 15 commands queued. When it starts with 17 commands queued, its 30th beat is refused.
- R6: A read beat (`wr_i`=0) completes only when the queue is empty. Its wait in cycles equals the edge after the last drain minus the start edge (zero if the queue is already empty), and the returned data reflects every earlier write.
- R7: In plain mode (`mux_i`=0), a burst starts on the edge where `sel_ni` and `strb_ni` are both low. The start address is `addr_i` on that edge, and `addr_i` is ignored on later beats.
- R8: In multiplexed mode (`mux_i`=1), `addr_i` is captured only on an edge where `addr_lat_i` is high and `sel_ni` is low. Later beats use the captured address plus the beat index and ignore `addr_i`. Without a valid capture, a strobe produces no beat.
- R9: A burst ends on the first edge where `sel_ni` or `strb_ni` is high, and `rdy_no` is high in the following cycle.
- R10: A beat with `is_reg_i`=1 at its start targets the register file at index `addr[REG_AW-1:0]` and leaves the memory untouched. `is_reg_i`=0 targets the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for host bus and drain engine |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ni | input | 1 | Host select, active low |
| strb_ni | input | 1 | Host data strobe, active low |
| wr_i | input | 1 | Burst direction, 1 = write, 0 = read |
| is_reg_i | input | 1 | Target, 1 = register file, 0 = memory |
| mux_i | input | 1 | Bus mode, 1 = multiplexed sequential |
| addr_lat_i | input | 1 | Address-latch strobe, multiplexed mode |
| addr_i | input | AW | Word address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid while rdy_no is low on a read |
| rdy_no | output | 1 | Data ready, active low |
| stop_no | output | 1 | Burst stop, active low |

## Verification
The key coincidence is a host push landing on the same edge as a drain pop while the queue sits one entry short of full, or exactly full. The bench provokes it by queueing 30 or 34 commands with a single burst, idling for one cycle, and then running a 32-beat burst. The drain phase is thereby fixed, and the bench knows which beats share an edge with a pop. The bench derives the refusal index from queue arithmetic and compares `stop_no` and `rdy_no` on each beat against it. It then reads the region back to confirm that the refused beats left no trace.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_BEAT = 2'd1,
    HS_HALT = 2'd2
  } host_st_e;
endpackage

// File: rtl/pwb_cmd_fifo.sv
module pwb_cmd_fifo #(
  parameter int W     = 25,
  parameter int DEPTH = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [W-1:0]  store_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
  assign rdata_o = store_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push_i) store_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R3
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/pwb_drain_engine.sv
module pwb_drain_engine #(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int REG_AW    = 3,
  parameter int DRAIN_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_empty_i,
  input  logic          cmd_reg_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_data_i,
  output logic          pop_o,
  input  logic          rd_reg_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int MEM_N = 1 << AW;
  localparam int REG_N = 1 << REG_AW;

  logic [DW-1:0] mem_q [MEM_N];
  logic [DW-1:0] reg_q [REG_N];

  generate
    if (DRAIN_CYC <= 1) begin : g_every
      assign pop_o = !fifo_empty_i;
    end else begin : g_paced
      localparam int TW = $clog2(DRAIN_CYC);
      localparam logic [TW-1:0] TMAX = TW'(DRAIN_CYC - 1);
      logic [TW-1:0] tmr_q;

      assign pop_o = !fifo_empty_i && (tmr_q == TMAX);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                    tmr_q <= '0;
        else if (fifo_empty_i || pop_o) tmr_q <= '0;
        else                            tmr_q <= tmr_q + 1'b1;
      end

      // R3
      drain_pace_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_o |=> !pop_o);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_N; i++) mem_q[i] <= '0;
      for (int i = 0; i < REG_N; i++) reg_q[i] <= '0;
    end else if (pop_o) begin
      if (cmd_reg_i) reg_q[cmd_addr_i[REG_AW-1:0]] <= cmd_data_i;
      else           mem_q[cmd_addr_i]             <= cmd_data_i;
    end
  end

  assign rd_data_o = rd_reg_i ? reg_q[rd_addr_i[REG_AW-1:0]] : mem_q[rd_addr_i];
endmodule

// File: rtl/pwb_host_if.sv
module pwb_host_if
  import pwb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_ni,
  input  logic          strb_ni,
  input  logic          wr_i,
  input  logic          is_reg_i,
  input  logic          mux_i,
  input  logic          addr_lat_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          fifo_full_i,
  input  logic          fifo_empty_i,
  output logic          push_o,
  output logic          push_reg_o,
  output logic [AW-1:0] push_addr_o,
  output logic [DW-1:0] push_data_o,
  output logic          rd_en_o,
  output logic          rd_reg_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic [DW-1:0] rdata_o,
  output logic          rdy_no,
  output logic          stop_no
);
  host_st_e      st_q;
  logic [AW-1:0] bur_addr_q, lat_addr_q, cur_addr;
  logic          bur_reg_q, bur_wr_q, lat_reg_q, lat_vld_q;
  logic          beat_req, start_ok, in_beat, cur_reg, cur_wr, refuse, idle;

  assign idle     = (st_q == HS_IDLE);
  assign beat_req = !sel_ni && !strb_ni;
  // multiplexed start needs a captured address and a finished address phase
  assign start_ok = mux_i ? (lat_vld_q && !addr_lat_i) : 1'b1;
  assign in_beat  = beat_req && ((idle && start_ok) || (st_q == HS_BEAT));
  assign cur_addr = idle ? (mux_i ? lat_addr_q : addr_i) : bur_addr_q;
  assign cur_reg  = idle ? (mux_i ? lat_reg_q : is_reg_i) : bur_reg_q;
  assign cur_wr   = idle ? wr_i : bur_wr_q;

  assign push_o      = in_beat && cur_wr && !fifo_full_i;
  assign refuse      = in_beat && cur_wr && fifo_full_i;
  assign rd_en_o     = in_beat && !cur_wr && fifo_empty_i;
  assign push_reg_o  = cur_reg;
  assign push_addr_o = cur_addr;
  assign push_data_o = wdata_i;
  assign rd_reg_o    = cur_reg;
  assign rd_addr_o   = cur_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= HS_IDLE;
      bur_addr_q <= '0;
      bur_reg_q  <= 1'b0;
      bur_wr_q   <= 1'b0;
      lat_addr_q <= '0;
      lat_reg_q  <= 1'b0;
      lat_vld_q  <= 1'b0;
      rdata_o    <= '0;
      rdy_no     <= 1'b1;
      stop_no    <= 1'b1;
    end else begin
      case (st_q)
        HS_IDLE: begin
          if (in_beat) begin
            st_q      <= HS_BEAT;
            bur_reg_q <= cur_reg;
            bur_wr_q  <= cur_wr;
          end
          if (mux_i && !sel_ni && addr_lat_i) begin
            lat_addr_q <= addr_i;
            lat_reg_q  <= is_reg_i;
            lat_vld_q  <= 1'b1;
          end
        end
        HS_BEAT: begin
          if (!beat_req) begin
            st_q      <= HS_IDLE;
            lat_vld_q <= 1'b0;
          end
        end
        HS_HALT: begin
          if (sel_ni) begin
            st_q      <= HS_IDLE;
            stop_no   <= 1'b1;
            lat_vld_q <= 1'b0;
          end
        end
        default: st_q <= HS_IDLE;
      endcase

      if (in_beat) bur_addr_q <= (push_o || rd_en_o) ? cur_addr + 1'b1 : cur_addr;
      rdy_no <= !(push_o || rd_en_o);
      if (rd_en_o) rdata_o <= rd_data_i;
      if (refuse) begin
        st_q    <= HS_HALT;
        stop_no <= 1'b0;
      end
    end
  end

  // R4
  stop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_no |-> rdy_no);
  // R4
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_no) |-> $past(sel_ni));
  // R2
  push_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !rdy_no);
  // R9
  burst_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == HS_BEAT && (sel_ni || strb_ni)) |=> rdy_no);
endmodule

// File: rtl/posted_write_bridge.sv
module posted_write_bridge #(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int DEPTH     = 32,
  parameter int REG_AW    = 3,
  parameter int DRAIN_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_ni,
  input  logic          strb_ni,
  input  logic          wr_i,
  input  logic          is_reg_i,
  input  logic          mux_i,
  input  logic          addr_lat_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rdy_no,
  output logic          stop_no
);
  localparam int CMD_W = 1 + AW + DW;

  logic             push, pop, full, empty, rd_en, rd_reg, push_reg;
  logic [AW-1:0]    push_addr, rd_addr;
  logic [DW-1:0]    push_data, rd_data;
  logic [CMD_W-1:0] cmd_in, cmd_out;

  assign cmd_in = {push_reg, push_addr, push_data};

  pwb_host_if #(.AW(AW), .DW(DW)) u_host (
    .clk_i, .rst_ni, .sel_ni, .strb_ni, .wr_i, .is_reg_i, .mux_i, .addr_lat_i,
    .addr_i, .wdata_i,
    .fifo_full_i (full),
    .fifo_empty_i(empty),
    .push_o      (push),
    .push_reg_o  (push_reg),
    .push_addr_o (push_addr),
    .push_data_o (push_data),
    .rd_en_o     (rd_en),
    .rd_reg_o    (rd_reg),
    .rd_addr_o   (rd_addr),
    .rd_data_i   (rd_data),
    .rdata_o, .rdy_no, .stop_no
  );

  pwb_cmd_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (push),
    .wdata_i(cmd_in),
    .pop_i  (pop),
    .rdata_o(cmd_out),
    .full_o (full),
    .empty_o(empty)
  );

  pwb_drain_engine #(.AW(AW), .DW(DW), .REG_AW(REG_AW), .DRAIN_CYC(DRAIN_CYC)) u_drain (
    .clk_i, .rst_ni,
    .fifo_empty_i(empty),
    .cmd_reg_i   (cmd_out[CMD_W-1]),
    .cmd_addr_i  (cmd_out[DW +: AW]),
    .cmd_data_i  (cmd_out[DW-1:0]),
    .pop_o       (pop),
    .rd_reg_i    (rd_reg),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data)
  );

  // R6
  read_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en |-> !pop);
  // R1
  reset_idle_chk: assert property (@(posedge clk_i) !rst_ni |=> (rdy_no && stop_no));
endmodule

// File: tb/posted_write_bridge_tb.sv
`timescale 1ns/1ps
module posted_write_bridge_tb;
  localparam int AW = 8, DW = 16, DEPTH = 32, REG_AW = 3, DRAIN = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b1, strb = 1'b1, wr = 1'b0, is_reg = 1'b0, mux = 1'b0, alat = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic rdy_n, stop_n;

  logic [DW-1:0] mem_m [1 << AW];
  logic [DW-1:0] reg_m [1 << REG_AW];
  int n_chk = 0, n_fail = 0, cyc = 0, e0 = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  posted_write_bridge #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .REG_AW(REG_AW), .DRAIN_CYC(DRAIN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_ni(sel), .strb_ni(strb), .wr_i(wr), .is_reg_i(is_reg),
    .mux_i(mux), .addr_lat_i(alat), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rdy_no(rdy_n), .stop_no(stop_n)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic idle(input int n);
    sel = 1'b1; strb = 1'b1; alat = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic addr_phase(input bit m, input logic [AW-1:0] base);
    mux = m;
    addr = base;
    if (m) begin
      sel = 1'b0; strb = 1'b1; alat = 1'b1;
      @(negedge clk);
      alat = 1'b0;
    end
  endtask

  function automatic int first_full(input int q, input int n);
    for (int k = 0; k < n; k++)
      if (q + k - k / DRAIN >= DEPTH) return k;
    return -1;
  endfunction

  task automatic wr_burst(input bit m, input logic [AW-1:0] base, input int n, input bit rg,
                          input logic [DW-1:0] seed, input int refuse_at);
    logic [AW-1:0] a;
    a = base; wr = 1'b1; is_reg = rg;
    addr_phase(m, base);
    sel = 1'b0; strb = 1'b0;
    for (int k = 0; k < n; k++) begin
      wdata = seed + DW'(k);
      if (k == 0) e0 = cyc + 1;
      @(negedge clk);
      addr = ~base;  // R7 R8: must be ignored after the start
      is_reg = ~rg;
      if (k == refuse_at) begin
        chk(!stop_n && rdy_n, "R4 refused beat stop/rdy", {stop_n, rdy_n}, 2'b01);
        break;
      end
      chk(!rdy_n && stop_n, "R2 write beat acknowledged", {stop_n, rdy_n}, 2'b10);
      if (rg) reg_m[a[REG_AW-1:0]] = wdata;
      else    mem_m[a] = wdata;
      a = a + 1'b1;
    end
    if (refuse_at >= 0 && refuse_at < n) begin
      @(negedge clk);
      chk(!stop_n, "R4 stop held while selected", stop_n, 0);
    end
    sel = 1'b1; strb = 1'b1;
    @(negedge clk);
    chk(rdy_n && stop_n, "R9 R4 burst end releases", {stop_n, rdy_n}, 2'b11);
  endtask

  task automatic rd_burst(input bit m, input logic [AW-1:0] base, input int n, input bit rg,
                          input int exp_wait, input string tag);
    int idx, s, guard;
    logic [AW-1:0] a;
    logic [DW-1:0] ev;
    wr = 1'b0; is_reg = rg;
    addr_phase(m, base);
    sel = 1'b0; strb = 1'b0;
    s = cyc + 1; idx = 0; guard = 0;
    while (idx < n && guard < 400) begin
      @(negedge clk);
      guard++;
      addr = ~base;
      is_reg = ~rg;
      if (!rdy_n) begin
        if (idx == 0 && exp_wait >= 0)
          chk(cyc - s == exp_wait, "R6 read wait cycles", cyc - s, exp_wait);
        a = base + AW'(idx);
        ev = rg ? reg_m[a[REG_AW-1:0]] : mem_m[a];
        chk(rdata == ev, tag, rdata, ev);
        idx++;
      end
    end
    chk(idx == n, "R6 read beats completed", idx, n);
    sel = 1'b1; strb = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int q, ff, s;
    for (int i = 0; i < (1 << AW); i++) mem_m[i] = '0;
    for (int i = 0; i < (1 << REG_AW); i++) reg_m[i] = '0;
    repeat (3) @(negedge clk);
    chk(rdy_n && stop_n, "R1 outputs during reset", {stop_n, rdy_n}, 2'b11);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy_n && stop_n, "R1 outputs after reset", {stop_n, rdy_n}, 2'b11);
    rd_burst(1'b0, 8'h00, 4, 1'b0, 0, "R1 memory reads zero");
    rd_burst(1'b0, 8'h00, 8, 1'b1, 0, "R1 registers read zero");

    // R5 start with 15 queued: no stop over 32 beats
    wr_burst(1'b0, 8'h00, 30, 1'b0, 16'h1000, -1);
    q = 30 - 30 / DRAIN;
    ff = first_full(q, 32);
    chk(q == 15 && ff == -1, "R5 arithmetic for 15 queued", ff, -1);
    wr_burst(1'b0, 8'h40, 32, 1'b0, 16'h2000, ff);
    idle(80);

    // R5 start with 17 queued: 30th beat refused
    wr_burst(1'b0, 8'h80, 34, 1'b0, 16'h3000, -1);
    q = 34 - 34 / DRAIN;
    ff = first_full(q, 32);
    chk(q == 17 && ff == 29, "R5 arithmetic for 17 queued", ff, 29);
    wr_burst(1'b0, 8'hC0, 32, 1'b0, 16'h4000, ff);
    idle(80);
    rd_burst(1'b0, 8'h00, 30, 1'b0, 0, "R3 drained data region A");
    rd_burst(1'b0, 8'h40, 32, 1'b0, 0, "R5 no-stop burst data");
    rd_burst(1'b0, 8'h80, 34, 1'b0, 0, "R3 drained data region C");
    rd_burst(1'b0, 8'hC0, 32, 1'b0, 0, "R4 refused beats not stored");

    // R6 R3 latency sweep against queue depth
    for (int n = 1; n < DEPTH; n++) begin
      idle(2 * DEPTH * DRAIN);
      wr_burst(1'b0, AW'(n * 5), n, 1'b0, DW'(n * 16'h0111), -1);
      s = cyc + 1;
      rd_burst(1'b0, AW'(n * 5 + n - 1), 1, 1'b0,
               (e0 + DRAIN * n + 1 > s) ? e0 + DRAIN * n + 1 - s : 0, "R6 read sees last write");
    end

    // R10 register target and ordering
    idle(80);
    wr_burst(1'b0, 8'h0B, 2, 1'b1, 16'hA5A0, -1);
    rd_burst(1'b0, 8'h0B, 2, 1'b1, -1, "R10 register read after posted write");
    rd_burst(1'b0, 8'h0B, 2, 1'b0, 0, "R10 memory untouched by register write");

    // R8 latch without select is ignored
    idle(2);
    mux = 1'b1; wr = 1'b1; addr = 8'h33; sel = 1'b1; alat = 1'b1;
    @(negedge clk);
    alat = 1'b0; sel = 1'b0; strb = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(rdy_n, "R8 no beat without valid latch", rdy_n, 1);
    end
    idle(2);
    rd_burst(1'b0, 8'h33, 1, 1'b0, 0, "R8 ignored burst wrote nothing");

    // R8 multiplexed sequential bursts
    wr_burst(1'b1, 8'h20, 5, 1'b0, 16'h5550, -1);
    rd_burst(1'b1, 8'h20, 5, 1'b0, -1, "R8 multiplexed burst data");
    wr_burst(1'b1, 8'h02, 3, 1'b1, 16'h6660, -1);
    rd_burst(1'b1, 8'h02, 3, 1'b1, -1, "R8 R10 multiplexed register burst");

    // R7 plain burst restarts with a fresh address, R9 strobe-only end
    wr_burst(1'b0, 8'hF0, 4, 1'b0, 16'h7770, -1);
    mux = 1'b0; wr = 1'b0; is_reg = 1'b0; addr = 8'hF1; sel = 1'b0; strb = 1'b0;
    repeat (12) @(negedge clk);
    strb = 1'b1;
    @(negedge clk);
    chk(rdy_n, "R9 strobe release ends burst", rdy_n, 1);
    idle(1);
    rd_burst(1'b0, 8'hF2, 2, 1'b0, 0, "R7 start address taken from addr_i");

    report();
  end
endmodule